// File: doc/BRIEF.md
# Flash Page-Program Command Sequencer

This block sits between a 32-bit CPU write port and a small on-chip flash array model. It watches bus writes for a three-write unlock/command sequence. Once the third write is accepted it goes busy and collects one full page of 64 words. The first data write must target the page-top byte address. Each later write supplies the next word in order. Every word is merged into the array as the AND of the stored value and the written data, so programming can only clear bits.

Each page carries a program-once flag. The flag is set when a page program begins and cleared only by an erase of that page. A second program of the same page without an erase is refused and flagged. After the 64th word the block stays busy for a fixed number of cycles, then returns to idle. While busy, command writes and erase requests are ignored.

An active-low hardware reset aborts a program in progress. The page flag is not cleared by reset, so the partly written page must be erased before it can be programmed again. Software checks the result through a combinational read port.

The write port follows valid/ready rules. A write is taken on a rising edge where `bus_wvalid` and `bus_wready` are both high. `bus_wready` is low only in a cycle where an erase is being accepted. Valid may stay high across such a cycle, and the write is then taken on a later edge.

Top module: `flash_pgm_seq`

## Requirements
- R1: After reset `status` is 0 (bit 0 busy, bit 1 alignment error, bit 2 program-twice error) and `bus_wready` is 1 while no erase is requested.
- R2: The unlock sequence is the writes (0x5400, 0x000000AA), (0xAA00, 0x00000055), (0x5400, 0x000000A0) in that order. The busy bit is 1 in the cycle after the third is accepted. Any mismatch returns to idle without setting busy or an error and without touching the array.
- R3: The fourth write must have byte-address bits [7:0] equal to 0. Its data is ANDed into word 0 of the page selected by address bits [8+PG_W-1:8], and that page's program flag is set.
- R4: Writes five onward are ANDed into words 1..63 in order. Address bits [7:2] are ignored. Data 0xFFFFFFFF leaves an erased word at 0xFFFFFFFF.
- R5: The busy bit stays 1 for exactly PROG_CYC cycles after the edge that accepts the 64th word, then falls to 0.
- R6: While busy, erase requests are ignored and do not lower `bus_wready`. A command sequence written while the page is draining has no effect.
- R7: A fourth write with address bits [7:0] not 0 sets status bit 1 and returns to idle. The array and the page flag stay unchanged.
- R8: A data write with address bits [1:0] not 0 sets status bit 1 and ends the operation. Words already written stay written, and the page stays flagged.
- R9: A fourth write to a page whose flag is set sets status bit 2 and returns to idle. The array is not changed. Alignment is checked before the flag.
- R10: A reset during a page program clears `status`, but the page stays flagged, so a new program of it is refused until it is erased.
- R11: An erase request while not busy sets all 64 words of `erase_page` to 0xFFFFFFFF and clears that page's flag. `bus_wready` is 0 in that cycle.
- R12: Both error bits clear when the first unlock write is accepted.
- R13: `rd_data` shows the word at `rd_addr` (page bits [8+PG_W-1:8], word bits [7:2]). Higher address bits alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| bus_wvalid | input | 1 | Write request valid |
| bus_wready | output | 1 | Write accepted when high together with valid |
| bus_waddr | input | 16 | Byte address of the write |
| bus_wdata | input | 32 | Write data |
| erase_req | input | 1 | Erase request for one page |
| erase_page | input | PG_W | Page index to erase |
| rd_addr | input | 16 | Read byte address |
| rd_data | output | 32 | Stored word at rd_addr |
| status | output | 3 | {twice error, alignment error, busy} |

## Verification
Two functions can fall in the same cycle: an erase request and a bus write. The bench meets this in two ways. First, it raises `erase_req` while the sequencer is draining a finished page, together with a fresh unlock sequence. It judges that `bus_wready` stays high, that the page keeps its programmed data, and that busy does not return. Second, it raises an erase while idle. There it judges that ready drops for that single cycle and that the whole page reads back as ones.

// File: rtl/fps_pkg.sv
package fps_pkg;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 16;
  localparam int PAGE_WORDS = 64;
  localparam int WIDX_W     = $clog2(PAGE_WORDS);
  localparam int PAGE_OFS_W = WIDX_W + 2;

  localparam logic [ADDR_W-1:0] UNL_A1 = 16'h5400;
  localparam logic [ADDR_W-1:0] UNL_A2 = 16'hAA00;
  localparam logic [ADDR_W-1:0] UNL_A3 = 16'h5400;
  localparam logic [DATA_W-1:0] UNL_D1 = 32'h0000_00AA;
  localparam logic [DATA_W-1:0] UNL_D2 = 32'h0000_0055;
  localparam logic [DATA_W-1:0] UNL_D3 = 32'h0000_00A0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_UNL1, ST_UNL2, ST_TOP, ST_FILL, ST_DRAIN
  } seq_state_t;
endpackage

// File: rtl/fps_drain_timer.sv
module fps_drain_timer #(
  parameter int CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);
  localparam int CNT_W = $clog2(CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start) begin
      cnt_q <= CNT_W'(CYC - 1);
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = run_q && (cnt_q == '0);
endmodule

// File: rtl/fps_page_store.sv
module fps_page_store
  import fps_pkg::*;
#(
  parameter int PAGES = 4,
  parameter int PG_W  = $clog2(PAGES)
) (
  input  logic              clk,
  input  logic              erase_en,
  input  logic [PG_W-1:0]   erase_page,
  input  logic              we,
  input  logic              mark,
  input  logic [PG_W-1:0]   page,
  input  logic [WIDX_W-1:0] word,
  input  logic [DATA_W-1:0] data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [PAGES-1:0]  written
);
  localparam int DEPTH = PAGES * PAGE_WORDS;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PAGES-1:0]  flag_q;

  // Non-volatile state: no reset, only erase restores it.
  always_ff @(posedge clk) begin
    if (erase_en) begin
      for (int unsigned w = 0; w < PAGE_WORDS; w++)
        mem[{erase_page, WIDX_W'(w)}] <= '1;
      flag_q[erase_page] <= 1'b0;
    end else begin
      if (we)   mem[{page, word}] <= mem[{page, word}] & data;
      if (mark) flag_q[page]      <= 1'b1;
    end
  end

  assign rd_data = mem[{rd_addr[PAGE_OFS_W +: PG_W], rd_addr[2 +: WIDX_W]}];
  assign written = flag_q;
endmodule

// File: rtl/fps_cmd_seq.sv
module fps_cmd_seq
  import fps_pkg::*;
#(
  parameter int PAGES = 4,
  parameter int PG_W  = $clog2(PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PAGES-1:0]  written,
  input  logic              drain_done,
  output logic              busy,
  output logic              err_align,
  output logic              err_twice,
  output logic              st_we,
  output logic              st_mark,
  output logic [PG_W-1:0]   st_page,
  output logic [WIDX_W-1:0] st_word,
  output logic [DATA_W-1:0] st_data,
  output logic              drain_start
);
  seq_state_t        state_q, state_d;
  logic [PG_W-1:0]   page_q;
  logic [WIDX_W-1:0] word_q;
  logic              clr_err, set_align, set_twice;
  logic [PG_W-1:0]   pg_in;
  logic              hit1, hit2, hit3;

  assign pg_in = waddr[PAGE_OFS_W +: PG_W];
  assign hit1  = (waddr == UNL_A1) && (wdata == UNL_D1);
  assign hit2  = (waddr == UNL_A2) && (wdata == UNL_D2);
  assign hit3  = (waddr == UNL_A3) && (wdata == UNL_D3);

  always_comb begin
    state_d     = state_q;
    clr_err     = 1'b0;
    set_align   = 1'b0;
    set_twice   = 1'b0;
    st_we       = 1'b0;
    st_mark     = 1'b0;
    drain_start = 1'b0;
    unique case (state_q)
      ST_IDLE: if (fire && hit1) begin
        state_d = ST_UNL1;
        clr_err = 1'b1;
      end
      ST_UNL1: if (fire) state_d = hit2 ? ST_UNL2 : ST_IDLE;
      ST_UNL2: if (fire) state_d = hit3 ? ST_TOP : ST_IDLE;
      ST_TOP: if (fire) begin
        if (waddr[PAGE_OFS_W-1:0] != '0) begin
          set_align = 1'b1;
          state_d   = ST_IDLE;
        end else if (written[pg_in]) begin
          set_twice = 1'b1;
          state_d   = ST_IDLE;
        end else begin
          st_we   = 1'b1;
          st_mark = 1'b1;
          state_d = ST_FILL;
        end
      end
      ST_FILL: if (fire) begin
        if (waddr[1:0] != 2'b00) begin
          set_align = 1'b1;
          state_d   = ST_IDLE;
        end else begin
          st_we = 1'b1;
          if (word_q == WIDX_W'(PAGE_WORDS - 1)) begin
            drain_start = 1'b1;
            state_d     = ST_DRAIN;
          end
        end
      end
      ST_DRAIN: if (drain_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      page_q    <= '0;
      word_q    <= '0;
      err_align <= 1'b0;
      err_twice <= 1'b0;
    end else begin
      state_q <= state_d;
      if (clr_err) begin
        err_align <= 1'b0;
        err_twice <= 1'b0;
      end
      if (set_align) err_align <= 1'b1;
      if (set_twice) err_twice <= 1'b1;
      if (st_we) begin
        if (state_q == ST_TOP) begin
          page_q <= pg_in;
          word_q <= WIDX_W'(1);
        end else begin
          word_q <= word_q + 1'b1;
        end
      end
    end
  end

  assign busy    = (state_q == ST_TOP) || (state_q == ST_FILL) || (state_q == ST_DRAIN);
  assign st_page = (state_q == ST_TOP) ? pg_in : page_q;
  assign st_word = (state_q == ST_TOP) ? '0 : word_q;
  assign st_data = wdata;
endmodule

// File: rtl/flash_pgm_seq.sv
module flash_pgm_seq
  import fps_pkg::*;
#(
  parameter int PAGES    = 4,
  parameter int PROG_CYC = 8,
  parameter int PG_W     = $clog2(PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wvalid,
  output logic              bus_wready,
  input  logic [ADDR_W-1:0] bus_waddr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              erase_req,
  input  logic [PG_W-1:0]   erase_page,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [2:0]        status
);
  logic              busy, err_align, err_twice;
  logic              fire, erase_en;
  logic              st_we, st_mark, drain_start, drain_done;
  logic [PG_W-1:0]   st_page;
  logic [WIDX_W-1:0] st_word;
  logic [DATA_W-1:0] st_data;
  logic [PAGES-1:0]  written;

  assign erase_en   = erase_req && !busy;
  assign bus_wready = !erase_en;
  assign fire       = bus_wvalid && bus_wready;

  fps_cmd_seq #(.PAGES(PAGES), .PG_W(PG_W)) u_seq (
    .clk, .rst_n, .fire, .waddr(bus_waddr), .wdata(bus_wdata),
    .written, .drain_done, .busy, .err_align, .err_twice,
    .st_we, .st_mark, .st_page, .st_word, .st_data, .drain_start
  );

  fps_page_store #(.PAGES(PAGES), .PG_W(PG_W)) u_store (
    .clk, .erase_en, .erase_page, .we(st_we), .mark(st_mark),
    .page(st_page), .word(st_word), .data(st_data),
    .rd_addr, .rd_data, .written
  );

  fps_drain_timer #(.CYC(PROG_CYC)) u_timer (
    .clk, .rst_n, .start(drain_start), .done(drain_done)
  );

  assign status = {err_twice, err_align, busy};
endmodule

// File: rtl/fps_checker.sv
module fps_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wvalid,
  input logic        bus_wready,
  input logic        erase_req,
  input logic [15:0] rd_addr,
  input logic [31:0] rd_data,
  input logic [2:0]  status
);
  // R6
  erase_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_req && status[0]) |-> bus_wready);

  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> $past(bus_wvalid && bus_wready));

  // R7
  align_err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> $past(status[0]));

  // R9
  twice_err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[2]) |-> $past(status[0]));

  // R12
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(status[1]) || $fell(status[2])) |-> $past(bus_wvalid && bus_wready));

  // R13
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(rd_addr) && !$past(bus_wvalid) && !$past(erase_req)) |-> $stable(rd_data));
endmodule

bind flash_pgm_seq fps_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wvalid(bus_wvalid), .bus_wready(bus_wready),
  .erase_req(erase_req), .rd_addr(rd_addr), .rd_data(rd_data), .status(status)
);

// File: tb/flash_pgm_seq_bench.sv
module flash_pgm_seq_bench;
  localparam int CLK_P = 10;
  localparam int PAGES = 4;
  localparam int PCYC  = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wvalid = 1'b0;
  logic        bus_wready;
  logic [15:0] bus_waddr = '0;
  logic [31:0] bus_wdata = '0;
  logic        erase_req = 1'b0;
  logic [1:0]  erase_page = '0;
  logic [15:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic [2:0]  status;

  int checks = 0;
  int failures = 0;

  always #(CLK_P/2) clk = ~clk;

  flash_pgm_seq #(.PAGES(PAGES), .PROG_CYC(PCYC)) u_flash_pgm_seq (
    .clk, .rst_n, .bus_wvalid, .bus_wready, .bus_waddr, .bus_wdata,
    .erase_req, .erase_page, .rd_addr, .rd_data, .status
  );

  function automatic logic [31:0] pat(input logic [15:0] seed, input int i);
    return {seed, 10'd0, 6'(i)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wvalid = 1'b1; bus_waddr = a; bus_wdata = d;
    @(negedge clk);
    bus_wvalid = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic erase(input int pg);
    @(negedge clk);
    erase_req = 1'b1; erase_page = 2'(pg);
    #1 chk("R11 ready low during erase", 32'(bus_wready), 32'd0);
    @(negedge clk);
    erase_req = 1'b0;
  endtask

  task automatic unlock();
    bus_wr(16'h5400, 32'hAA);
    bus_wr(16'hAA00, 32'h55);
    bus_wr(16'h5400, 32'hA0);
  endtask

  // Programs all 64 words; later addresses are scrambled in bits [7:2].
  task automatic prog_page(input int pg, input logic [15:0] seed, input bit check_busy);
    logic [15:0] top;
    top = 16'(pg) << 8;
    unlock();
    if (check_busy) chk("R2 busy after third write", 32'(status), 32'd1);
    bus_wr(top, pat(seed, 0));
    for (int i = 1; i < 64; i++) bus_wr(top | 16'((63 - i) << 2), pat(seed, i));
  endtask

  task automatic t_reset_state();
    chk("R1 status after reset", 32'(status), 32'd0);
    chk("R1 ready after reset", 32'(bus_wready), 32'd1);
  endtask

  task automatic t_erase_all();
    logic [31:0] d;
    for (int p = 0; p < PAGES; p++) erase(p);
    rd(16'h0100, d); chk("R11 erased word 0", d, 32'hFFFF_FFFF);
    rd(16'h01FC, d); chk("R11 erased word 63", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_bad_unlock();
    logic [31:0] d;
    bus_wr(16'h5400, 32'hAA);
    bus_wr(16'hAA00, 32'h56);
    bus_wr(16'h5400, 32'hA0);
    chk("R2 mismatch leaves idle", 32'(status), 32'd0);
    bus_wr(16'h0100, 32'h0);
    rd(16'h0100, d); chk("R2 mismatch no array change", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_program_and_drain();
    logic [31:0] d;
    prog_page(1, 16'h1A2B, 1'b1);
    chk("R5 busy right after last word", 32'(status[0]), 32'd1);
    repeat (PCYC - 1) @(negedge clk);
    chk("R5 busy at last drain cycle", 32'(status[0]), 32'd1);
    @(negedge clk);
    chk("R5 busy low after drain", 32'(status), 32'd0);
    rd(16'h0100, d); chk("R3 word 0 programmed", d, pat(16'h1A2B, 0));
    rd(16'h0104, d); chk("R4 word 1 sequential", d, pat(16'h1A2B, 1));
    rd(16'h01FC, d); chk("R4 word 63 sequential", d, pat(16'h1A2B, 63));
    rd(16'h0500, d); chk("R13 alias to page 1", d, pat(16'h1A2B, 0));
    rd(16'h0000, d); chk("R13 page 0 untouched", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_drain_ignores();
    logic [31:0] d;
    unlock();
    bus_wr(16'h0200, 32'hFFFF_FFFF);
    for (int i = 1; i < 64; i++) bus_wr(16'h0200 | 16'(i << 2), (i == 5) ? 32'h0000_5555 : 32'hFFFF_FFFF);
    @(negedge clk);
    erase_req = 1'b1; erase_page = 2'd2;
    #1 chk("R6 ready high with erase while busy", 32'(bus_wready), 32'd1);
    @(negedge clk);
    erase_req = 1'b0;
    unlock();
    repeat (3) @(negedge clk);
    chk("R6 no busy from sequence during drain", 32'(status), 32'd0);
    rd(16'h0214, d); chk("R6 erase ignored while busy", d, 32'h0000_5555);
    rd(16'h0208, d); chk("R4 all-ones data keeps word erased", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_twice_and_clear();
    logic [31:0] d;
    unlock();
    bus_wr(16'h0100, 32'h0);
    chk("R9 second program flagged", 32'(status), 32'd4);
    rd(16'h0100, d); chk("R9 array unchanged", d, pat(16'h1A2B, 0));
    bus_wr(16'h5400, 32'hAA);
    chk("R12 errors cleared by unlock start", 32'(status), 32'd0);
    bus_wr(16'h1234, 32'h0);
  endtask

  task automatic t_misaligned();
    logic [31:0] d;
    unlock();
    bus_wr(16'h0304, 32'h0);
    chk("R7 misaligned top flagged", 32'(status), 32'd2);
    rd(16'h0304, d); chk("R7 array unchanged", d, 32'hFFFF_FFFF);
    unlock();
    chk("R12 align error cleared", 32'(status), 32'd1);
    bus_wr(16'h0300, 32'h1234_5678);
    chk("R7 page not marked by rejected top", 32'(status), 32'd1);
    bus_wr(16'h0302, 32'h0);
    chk("R8 misaligned data aborts", 32'(status), 32'd2);
    rd(16'h0300, d); chk("R8 earlier word kept", d, 32'h1234_5678);
    rd(16'h0304, d); chk("R8 later word untouched", d, 32'hFFFF_FFFF);
    unlock();
    bus_wr(16'h0300, 32'h0);
    chk("R8 page stays flagged", 32'(status), 32'd4);
  endtask

  task automatic t_reset_abort();
    logic [31:0] d;
    erase(3);
    unlock();
    bus_wr(16'h0300, 32'h1111_0000);
    for (int i = 1; i < 10; i++) bus_wr(16'h0300 | 16'(i << 2), 32'h0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R10 reset clears status", 32'(status), 32'd0);
    unlock();
    bus_wr(16'h0300, 32'h0);
    chk("R10 aborted page refused", 32'(status), 32'd4);
    rd(16'h0300, d); chk("R10 aborted data intact", d, 32'h1111_0000);
    erase(3);
    prog_page(3, 16'h00C3, 1'b0);
    repeat (PCYC + 1) @(negedge clk);
    chk("R11 erase re-enables program", 32'(status), 32'd0);
    rd(16'h03F0, d); chk("R11 reprogrammed word 60", d, pat(16'h00C3, 60));
  endtask

  initial begin
    #(CLK_P * 150000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_erase_all();
    t_bad_unlock();
    t_program_and_drain();
    t_drain_ignores();
    t_twice_and_clear();
    t_misaligned();
    t_reset_abort();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule